// File: doc/BRIEF.md
# Audio Sample-Clock Generator with Ratio Detection

This block derives all sample-rate timing of an audio converter from one system clock. When a mode pin pair selects a master setting, it divides the system clock to produce a bit clock and a frame clock for the serial audio link. The bit clock always runs at 64 periods per frame. The same divider also produces single-cycle enables at 128 and 64 times the sample rate for the filter and modulator logic. The legal system clock ratios per sample are 256, 384 and 512 in master mode. Because 384 is not a power of two, the bit clock divides the system clock by 6 for that ratio.

When the mode pins select slave operation, the frame clock arrives from an external timing master. The block synchronises it and counts system clocks between its rising edges. It then declares the ratio once two successive counts agree on a legal value: 256, 384, 512 or 768. The 768 ratio exists only in slave mode. While locked, the internal enables run at the detected ratio. A mismatch, an illegal period or a stalled frame clock drops the lock. In slave mode the bit-clock and frame-clock outputs stay low. All pins are plain control and status signals; no data stream passes through the block.

Top module: `audclk_gen`

## Requirements
- R1: Mode pins decode as 00 = slave with detection, 01 = master 512x, 10 = master 384x, 11 = master 256x. Ratio code values are 0 = 256x, 1 = 384x, 2 = 512x, 3 = 768x. In master mode `ratio_valid` is 1 and `ratio_code` shows the selected ratio.
- R2: In master mode `bclk_out` has a period of ratio/64 system clocks, and its high and low times are each ratio/128 clocks.
- R3: In master mode `lrclk_out` has a period equal to the ratio, with a 50 percent duty cycle.
- R4: In master mode `lrclk_out` changes only in a cycle where `bclk_out` falls, and each frame holds exactly 64 bit-clock periods.
- R5: `en_64fs` is a one-cycle pulse every ratio/64 clocks. `en_128fs` pulses every ratio/128 clocks and is high in every cycle where `en_64fs` is high.
- R6: In slave mode the block counts system clocks between rising edges of `lrclk_in`. It raises `ratio_valid`, with the matching code, once two consecutive counts equal the same legal ratio, and 768x is reported there.
- R7: In slave mode, an illegal period, or consecutive periods that differ, keeps `ratio_valid` low and both enables idle. `bclk_out` and `lrclk_out` stay low throughout slave mode.
- R8: In slave mode, if no rising edge of `lrclk_in` arrives for 2^CNT_W-1 system clocks, `ratio_valid` falls. It stays high for shorter gaps.
- R9: During reset all outputs are low and `ratio_valid` is 0 with mode 00. A change of the mode pins restarts the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Mode and master ratio select (R1) |
| lrclk_in | input | 1 | Frame clock from external master (slave mode) |
| bclk_out | output | 1 | Generated bit clock (master mode, else 0) |
| lrclk_out | output | 1 | Generated frame clock (master mode, else 0) |
| en_128fs | output | 1 | One-cycle enable at 128x sample rate |
| en_64fs | output | 1 | One-cycle enable at 64x sample rate |
| ratio_code | output | 2 | Active ratio code |
| ratio_valid | output | 1 | Ratio known: master mode, or slave lock |

## Verification
The hardest situation to reach from the ports is a frame clock that arrives every frame but never settles. The counter sees edges all the time, yet no two successive periods agree. The bench gets there by driving `lrclk_in` with a frame length that alternates between 256 and 512 clocks on every frame. It confirms that lock never appears. A second case stops the frame clock after lock. The bench samples `ratio_valid` once before the counter saturates and once after.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

  typedef enum logic [1:0] {
    RATIO_256 = 2'd0,
    RATIO_384 = 2'd1,
    RATIO_512 = 2'd2,
    RATIO_768 = 2'd3
  } ratio_e;

  localparam int unsigned NUM_RATIOS = 4;
  localparam int unsigned BITS_PER_FRAME = 64;
  localparam int unsigned PH_W = 4;

  function automatic int unsigned ratio_len(ratio_e r);
    case (r)
      RATIO_256: return 256;
      RATIO_384: return 384;
      RATIO_512: return 512;
      default:   return 768;
    endcase
  endfunction

  // System clocks per bit-clock period.
  function automatic logic [PH_W-1:0] bit_div(ratio_e r);
    return PH_W'(ratio_len(r) / BITS_PER_FRAME);
  endfunction

  function automatic ratio_e master_ratio(logic [1:0] m);
    case (m)
      2'b01:   return RATIO_512;
      2'b10:   return RATIO_384;
      default: return RATIO_256;
    endcase
  endfunction

endpackage

// File: rtl/audclk_ratio_det.sv
module audclk_ratio_det
  import audclk_pkg::*;
#(
  parameter int unsigned CNT_W       = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enable,
  input  logic   frame_in,
  output ratio_e ratio,
  output logic   locked
);

  localparam int unsigned SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0]  sync_sh;
  logic             frame_rise;
  logic [CNT_W-1:0] cnt_q, prev_q;
  logic             cnt_sat;
  logic             len_ok;
  ratio_e           len_code;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) sync_sh <= '0;
    else                   sync_sh <= {sync_sh[SH_W-2:0], frame_in};
  end

  assign frame_rise = sync_sh[SH_W-2] & ~sync_sh[SH_W-1];
  assign cnt_sat    = &cnt_q;

  always_comb begin
    len_ok   = 1'b0;
    len_code = RATIO_256;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (cnt_q == CNT_W'(ratio_len(ratio_e'(i)))) begin
        len_ok   = 1'b1;
        len_code = ratio_e'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      cnt_q  <= '0;
      prev_q <= '0;
      locked <= 1'b0;
      ratio  <= RATIO_256;
    end else if (frame_rise) begin
      cnt_q  <= CNT_W'(1);
      prev_q <= cnt_q;
      if (len_ok && cnt_q == prev_q) begin
        locked <= 1'b1;
        ratio  <= len_code;
      end else begin
        locked <= 1'b0;
      end
    end else if (cnt_sat) begin
      locked <= 1'b0;
      prev_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R6: lock is only ever gained on a frame edge
  p_lock_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(frame_rise));

  // R8: a stalled frame clock drops the lock
  p_stall_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cnt_sat && !frame_rise) |=> !locked);

endmodule

// File: rtl/audclk_divider.sv
module audclk_divider
  import audclk_pkg::*;
#(
  parameter int unsigned BIT_W = 6
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   restart,
  input  logic   is_master,
  input  ratio_e ratio,
  output logic   bclk,
  output logic   frame_clk,
  output logic   en_128,
  output logic   en_64
);

  localparam logic [BIT_W-1:0] HALF_BITS = BIT_W'(1 << (BIT_W - 1));

  logic [PH_W-1:0]  div_len, half_len, ph_q, ph_n;
  logic [BIT_W-1:0] bit_q, bit_n;
  logic             live_q;

  assign div_len  = bit_div(ratio);
  assign half_len = div_len >> 1;

  always_comb begin
    ph_n  = (ph_q >= div_len - PH_W'(1)) ? '0 : ph_q + PH_W'(1);
    bit_n = (ph_n == '0) ? bit_q + BIT_W'(1) : bit_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      // Next active cycle lands on phase 0 of the second half-frame.
      ph_q      <= div_len - PH_W'(1);
      bit_q     <= HALF_BITS - BIT_W'(1);
      bclk      <= 1'b0;
      frame_clk <= 1'b0;
      en_64     <= 1'b0;
      en_128    <= 1'b0;
      live_q    <= 1'b0;
    end else begin
      ph_q      <= ph_n;
      bit_q     <= bit_n;
      bclk      <= is_master & (ph_n >= half_len);
      frame_clk <= is_master & (bit_n < HALF_BITS);
      en_64     <= (ph_n == '0);
      en_128    <= (ph_n == '0) || (ph_n == half_len);
      live_q    <= 1'b1;
    end
  end

  // R4: frame clock moves only together with a bit-clock fall
  p_frame_on_bclk_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(live_q) && is_master && frame_clk != $past(frame_clk))
      |-> (!bclk && $past(bclk)));

  // R2: a running bit clock falls at the start of a bit period
  p_bclk_fall_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $fell(bclk)) |-> en_64);

  // R5: enables are single-cycle and nested
  p_en64_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_64 |=> !en_64);
  p_en64_in_en128_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_64 |-> en_128);

endmodule

// File: rtl/audclk_gen.sv
module audclk_gen
  import audclk_pkg::*;
#(
  parameter int unsigned CNT_W       = 11,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BIT_W       = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       lrclk_in,
  output logic       bclk_out,
  output logic       lrclk_out,
  output logic       en_128fs,
  output logic       en_64fs,
  output logic [1:0] ratio_code,
  output logic       ratio_valid
);

  logic [1:0] mode_q;
  logic       is_master, master_q;
  logic       det_locked, run, restart;
  ratio_e     det_ratio, act_ratio;

  assign is_master = (mode_sel != 2'b00);
  assign master_q  = (mode_q != 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= 2'b00;
    else        mode_q <= mode_sel;
  end

  audclk_ratio_det #(
    .CNT_W       (CNT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (!is_master),
    .frame_in (lrclk_in),
    .ratio    (det_ratio),
    .locked   (det_locked)
  );

  assign act_ratio = is_master ? master_ratio(mode_sel) : det_ratio;
  assign run       = is_master | det_locked;
  assign restart   = (mode_sel != mode_q) | !run;

  audclk_divider #(
    .BIT_W (BIT_W)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .is_master (is_master),
    .ratio     (act_ratio),
    .bclk      (bclk_out),
    .frame_clk (lrclk_out),
    .en_128    (en_128fs),
    .en_64     (en_64fs)
  );

  assign ratio_code  = act_ratio;
  assign ratio_valid = run;

  // R7: in slave mode the enables only run after a lock
  p_slave_enable_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_q && en_64fs) |-> $past(det_locked));

  // R7: generated clocks stay low in slave mode
  p_slave_clocks_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_q && !$past(master_q)) |-> (!bclk_out && !lrclk_out));

endmodule

// File: tb/audclk_gen_bench.sv
`timescale 1ns/1ps
module audclk_gen_bench;

  localparam int CNT_W = 11;
  localparam int WD_NS = 600000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       lrclk_in = 1'b0;
  logic       bclk_out, lrclk_out, en_128fs, en_64fs, ratio_valid;
  logic [1:0] ratio_code;

  int n_chk = 0;
  int n_bad = 0;

  // frame clock source for slave tests
  logic lr_en = 1'b0;
  logic alt = 1'b0;
  int   req_per = 256;
  int   cur_per = 256;
  int   lcnt = 0;

  always #2.5 clk = ~clk;

  audclk_gen #(.CNT_W(CNT_W)) u_audclk_gen (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .lrclk_in(lrclk_in),
    .bclk_out(bclk_out), .lrclk_out(lrclk_out), .en_128fs(en_128fs),
    .en_64fs(en_64fs), .ratio_code(ratio_code), .ratio_valid(ratio_valid)
  );

  always @(negedge clk) begin
    if (!lr_en) begin
      lcnt     <= 0;
      lrclk_in <= 1'b0;
      cur_per  <= req_per;
    end else begin
      if (lcnt >= cur_per - 1) begin
        lcnt <= 0;
        if (alt) cur_per <= (cur_per == 256) ? 512 : 256;
        else     cur_per <= req_per;
      end else begin
        lcnt <= lcnt + 1;
      end
      lrclk_in <= (lcnt < cur_per / 2);
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int code_of(int r);
    case (r)
      256: return 0;
      384: return 1;
      512: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic run_master(input logic [1:0] m, input int r);
    int div = r / 64;
    int hf = r / 128;
    int last_fall = -1, last_lr = -1, last64 = -1, last128 = -1;
    int hi_run = 0, n_fall = 0, n_lr = 0;
    bit rise_seen = 0;
    int e_bper = 0, e_bhi = 0, e_align = 0, e_lper = 0, e_lhi = 0;
    int e64 = 0, e128 = 0, e_code = 0, lr_hi = 0;
    logic pb, pl;
    mode_sel = m;
    repeat (20) @(negedge clk);
    pb = bclk_out;
    pl = lrclk_out;
    for (int t = 0; t < 3 * r; t++) begin
      @(negedge clk);
      if (bclk_out && !pb) begin hi_run = 1; rise_seen = 1; end
      else if (bclk_out) hi_run++;
      if (pb && !bclk_out) begin
        if (last_fall >= 0 && t - last_fall != div) e_bper++;
        if (rise_seen && hi_run != hf) e_bhi++;
        last_fall = t;
        n_fall++;
      end
      if (lrclk_out != pl && !(pb && !bclk_out)) e_align++;
      if (lrclk_out) lr_hi++;
      if (lrclk_out && !pl) begin
        if (last_lr >= 0 && t - last_lr != r) e_lper++;
        last_lr = t;
        n_lr++;
      end
      if (en_64fs) begin
        if (last64 >= 0 && t - last64 != div) e64++;
        if (!en_128fs) e64++;
        last64 = t;
      end
      if (en_128fs) begin
        if (last128 >= 0 && t - last128 != hf) e128++;
        last128 = t;
      end
      if (!ratio_valid || ratio_code != 2'(code_of(r))) e_code++;
      pb = bclk_out;
      pl = lrclk_out;
    end
    chk(e_code == 0, "R1 master ratio code/valid", e_code, 0);
    chk(e_bper == 0, "R2 bclk period", e_bper, 0);
    chk(e_bhi == 0, "R2 bclk high time", e_bhi, 0);
    chk(e_lper == 0 && n_lr >= 2, "R3 lrclk period", e_lper, 0);
    if (lr_hi < 3 * r / 2 - r / 2 || lr_hi > 3 * r / 2 + r / 2) e_lhi++;
    chk(e_lhi == 0, "R3 lrclk duty", lr_hi, 3 * r / 2);
    chk(e_align == 0, "R4 lrclk aligned to bclk fall", e_align, 0);
    chk(n_fall == 3 * 64, "R4 bit clocks per 3 frames", n_fall, 192);
    chk(e64 == 0, "R5 en_64fs spacing", e64, 0);
    chk(e128 == 0, "R5 en_128fs spacing", e128, 0);
  endtask

  task automatic run_slave(input int r);
    int div = r / 64;
    int hf = r / 128;
    int last64 = -1, last128 = -1, e64 = 0, e128 = 0, n64 = 0, e_clk = 0;
    mode_sel = 2'b00;
    alt = 1'b0;
    req_per = r;
    lr_en = 1'b1;
    repeat (6 * r) @(negedge clk);
    chk(ratio_valid == 1'b1, "R6 slave lock", ratio_valid, 1);
    chk(ratio_code == 2'(code_of(r)), "R6 slave ratio code", ratio_code, code_of(r));
    for (int t = 0; t < 2 * r; t++) begin
      @(negedge clk);
      if (en_64fs) begin
        if (last64 >= 0 && t - last64 != div) e64++;
        last64 = t;
        n64++;
      end
      if (en_128fs) begin
        if (last128 >= 0 && t - last128 != hf) e128++;
        last128 = t;
      end
      if (bclk_out || lrclk_out) e_clk++;
    end
    chk(e64 == 0 && n64 == 128, "R5 slave en_64fs spacing", n64, 128);
    chk(e128 == 0, "R5 slave en_128fs spacing", e128, 0);
    chk(e_clk == 0, "R7 slave clocks held low", e_clk, 0);
  endtask

  task automatic run_slave_bad(input bit alternate, input int r, input string what);
    int n_valid = 0, n_en = 0;
    mode_sel = 2'b00;
    alt = alternate;
    req_per = r;
    lr_en = 1'b1;
    repeat (4 * 512) @(negedge clk);
    for (int t = 0; t < 6 * 512; t++) begin
      @(negedge clk);
      if (ratio_valid) n_valid++;
      if (en_64fs || en_128fs) n_en++;
    end
    chk(n_valid == 0, {what, " no lock"}, n_valid, 0);
    chk(n_en == 0, {what, " enables idle"}, n_en, 0);
    alt = 1'b0;
  endtask

  initial begin
    #(WD_NS);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    // R9 reset state
    chk({bclk_out, lrclk_out, en_128fs, en_64fs, ratio_valid} == 5'b0,
        "R9 reset outputs low", {bclk_out, lrclk_out, en_128fs, en_64fs, ratio_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ratio_valid == 1'b0, "R9 slave unlocked after reset", ratio_valid, 0);

    // R1..R5 master sweep, each mode entered from another (R9 restart)
    run_master(2'b11, 256);
    run_master(2'b10, 384);
    run_master(2'b01, 512);
    run_master(2'b10, 384);

    // R6 slave detection over all legal ratios including 768
    run_slave(256);
    run_slave(384);
    run_slave(512);
    run_slave(768);

    // R7 illegal period and unstable periods
    run_slave_bad(1'b0, 300, "R7 illegal period");
    run_slave_bad(1'b1, 256, "R7 alternating periods");

    // R8 stalled frame clock
    run_slave(256);
    lr_en = 1'b0;
    repeat (1500) @(negedge clk);
    chk(ratio_valid == 1'b1, "R8 lock held during short gap", ratio_valid, 1);
    repeat (700) @(negedge clk);
    chk(ratio_valid == 1'b0, "R8 lock lost after stall", ratio_valid, 0);

    // R9 switch back to master after slave
    run_master(2'b11, 256);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule